// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the device end of a byte-wide mailbox between a host and an embedded controller. The host sees two ports on a small I/O bus. Offset 0x0 is the data port. Offset 0x4 returns status when read and takes a command opcode when written. Every byte the host writes is held in an input latch until an internal sequencer consumes it. A command opcode picks the transaction. The data bytes that follow it supply an address and, for a store, the value.

Behind the sequencer sits a generic 256-location register port: an address, a write strobe with write data, and a read strobe whose data returns one cycle later. Another block implements the actual register contents there. Two status flags pace the host. The input-full flag says a written byte has not yet been consumed. The output-full flag says a byte is waiting in the data port.

Status byte layout: bit 0 output-full, bit 1 input-full, bit 3 last accepted write was a command, bit 4 burst flag. All other bits read 0.

Top module: `ec_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00 and the data port reads 0x00.
- R2: A host write to offset 0x0 or 0x4 while input-full (status bit 1) is clear sets input-full, and input-full stays set for exactly LATENCY cycles before it clears.
- R3: A host write made while input-full is set is discarded: it changes neither the held byte nor the command flag.
- R4: Status bit 3 is 1 after an accepted write to offset 0x4 and 0 after an accepted write to offset 0x0.
- R5: Opcode 0x81 followed by two data bytes (an address, then a value) produces exactly one register write strobe carrying that address and value.
- R6: Opcode 0x80 followed by one data byte (an address) issues one register read; the returned value appears at the data port and output-full (status bit 0) sets.
- R7: A host read of the data port clears output-full.
- R8: Opcode 0x82 sets status bit 4 and opcode 0x83 clears it.
- R9: Opcode 0x84 places 0x00 in the data port and sets output-full.
- R10: A command accepted in the middle of a sequence abandons that sequence; the bytes already given to it cause no register access.
- R11: Data bytes with no sequence pending, and data bytes that follow an opcode other than 0x80 to 0x84, cause no register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | PORT_AW | Host port offset (0x0 data, 0x4 status/command) |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Data port or status byte, selected by host_addr |
| reg_addr | output | ADDR_W | Register space address |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_wdata | output | DATA_W | Register write value |
| reg_rdata | input | DATA_W | Register read value, valid the cycle after reg_rd |

## Verification
The bench builds the block with LATENCY=3 and the full 8-bit register address. This lets it store a distinct computed value at all 256 locations and read each one back through the read opcode. A short latency leaves room to place a second host write while input-full is still set. The input-full window can then be measured and compared with LATENCY. Separate directed sequences cover abort by a new command, stray and unknown-opcode bytes, the burst flag and the query reply.

// File: rtl/ec_mbx_pkg.sv
// Shared constants for the host mailbox: command opcodes, status bit
// positions and the sequencer state encoding.
package ec_mbx_pkg;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    localparam int STB_OUT_FULL = 0;
    localparam int STB_IN_FULL  = 1;
    localparam int STB_IS_CMD   = 3;
    localparam int STB_BURST    = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA,
        SQ_RD_ISSUE,
        SQ_RD_LOAD
    } seq_state_t;

endpackage

// File: rtl/ec_mbx_inlatch.sv
// Input holding register with the input-full flag.
// Captures one host byte while empty, marks whether it came through the
// command port, and offers it to the sequencer LATENCY cycles later.
// Assumes LATENCY >= 2. Bytes written while full are dropped.
module ec_mbx_inlatch #(
    parameter int DATA_W  = 8,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_is_cmd,
    input  logic [DATA_W-1:0] wr_byte,
    output logic              full,
    output logic              held_cmd,
    output logic [DATA_W-1:0] held_byte,
    output logic              consume
);

    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] wait_cnt;

    // The byte is handed over on the cycle the wait counter has run out.
    always_comb consume = full && (wait_cnt == '0);

    // Capture, count down and release the held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            held_cmd  <= 1'b0;
            held_byte <= '0;
            wait_cnt  <= '0;
        end else if (full) begin
            if (wait_cnt == '0) begin
                full <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end else if (wr_en) begin
            full      <= 1'b1;
            held_cmd  <= wr_is_cmd;
            held_byte <= wr_byte;
            wait_cnt  <= CW'(LATENCY - 1);
        end
    end

endmodule

// File: rtl/ec_mbx_seq.sv
// Command sequencer. Decodes opcodes from the input latch and turns the
// following data bytes into register reads and writes. Any opcode abandons
// a sequence in progress. Assumes ADDR_W <= DATA_W and a register port
// whose read data is valid one cycle after the read strobe.
module ec_mbx_seq
    import ec_mbx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              consume,
    input  logic              in_cmd,
    input  logic [DATA_W-1:0] in_byte,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              load,
    output logic [DATA_W-1:0] load_val,
    output logic              burst
);

    seq_state_t state;

    // Step the sequence on each consumed byte and finish pending reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            load      <= 1'b0;
            load_val  <= '0;
            burst     <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            load   <= 1'b0;
            if (consume && in_cmd) begin
                case (in_byte)
                    DATA_W'(OP_READ):      state <= SQ_RD_ADDR;
                    DATA_W'(OP_WRITE):     state <= SQ_WR_ADDR;
                    DATA_W'(OP_BURST_ON):  begin burst <= 1'b1; state <= SQ_IDLE; end
                    DATA_W'(OP_BURST_OFF): begin burst <= 1'b0; state <= SQ_IDLE; end
                    DATA_W'(OP_QUERY): begin
                        load     <= 1'b1;
                        load_val <= '0;
                        state    <= SQ_IDLE;
                    end
                    default:               state <= SQ_IDLE;
                endcase
            end else if (consume) begin
                case (state)
                    SQ_RD_ADDR: begin
                        reg_addr <= in_byte[ADDR_W-1:0];
                        reg_rd   <= 1'b1;
                        state    <= SQ_RD_ISSUE;
                    end
                    SQ_WR_ADDR: begin
                        reg_addr <= in_byte[ADDR_W-1:0];
                        state    <= SQ_WR_DATA;
                    end
                    SQ_WR_DATA: begin
                        reg_wdata <= in_byte;
                        reg_wr    <= 1'b1;
                        state     <= SQ_IDLE;
                    end
                    default: state <= state;
                endcase
            end else begin
                case (state)
                    SQ_RD_ISSUE: state <= SQ_RD_LOAD;
                    SQ_RD_LOAD: begin
                        load     <= 1'b1;
                        load_val <= reg_rdata;
                        state    <= SQ_IDLE;
                    end
                    default: state <= state;
                endcase
            end
        end
    end

endmodule

// File: rtl/ec_mbx_outport.sv
// Output data register with the output-full flag, and status byte assembly.
// A load from the sequencer wins over a host read in the same cycle.
module ec_mbx_outport
    import ec_mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              host_take,
    input  logic              in_full,
    input  logic              in_cmd,
    input  logic              burst,
    output logic              out_full,
    output logic [DATA_W-1:0] out_byte,
    output logic [DATA_W-1:0] status
);

    // Hold the reply byte and track whether the host has taken it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0;
            out_byte <= '0;
        end else if (load) begin
            out_full <= 1'b1;
            out_byte <= load_val;
        end else if (host_take) begin
            out_full <= 1'b0;
        end
    end

    // Pack the flags into the status byte.
    always_comb begin
        status               = '0;
        status[STB_OUT_FULL] = out_full;
        status[STB_IN_FULL]  = in_full;
        status[STB_IS_CMD]   = in_cmd;
        status[STB_BURST]    = burst;
    end

endmodule

// File: rtl/ec_mailbox.sv
// Host mailbox top. Decodes the two host ports, feeds written bytes through
// the input latch to the sequencer, and returns either the reply byte or the
// status byte. Offsets other than 0x0 and 0x4 are ignored.
module ec_mailbox #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 8,
    parameter int PORT_AW = 3,
    parameter int LATENCY = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic [DATA_W-1:0]  reg_wdata,
    input  logic [DATA_W-1:0]  reg_rdata
);

    localparam logic [PORT_AW-1:0] DATA_OFS = PORT_AW'(0);
    localparam logic [PORT_AW-1:0] CTRL_OFS = PORT_AW'(4);

    logic              sel_data;
    logic              sel_ctrl;
    logic              ibf;
    logic              in_cmd;
    logic [DATA_W-1:0] in_byte;
    logic              consume;
    logic              load;
    logic [DATA_W-1:0] load_val;
    logic              burst;
    logic              obf;
    logic [DATA_W-1:0] out_byte;
    logic [DATA_W-1:0] status;

    // Port decode.
    always_comb begin
        sel_data = (host_addr == DATA_OFS);
        sel_ctrl = (host_addr == CTRL_OFS);
    end

    ec_mbx_inlatch #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_inlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr && (sel_data || sel_ctrl)),
        .wr_is_cmd (sel_ctrl),
        .wr_byte   (host_wdata),
        .full      (ibf),
        .held_cmd  (in_cmd),
        .held_byte (in_byte),
        .consume   (consume)
    );

    ec_mbx_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .consume   (consume),
        .in_cmd    (in_cmd),
        .in_byte   (in_byte),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .load      (load),
        .load_val  (load_val),
        .burst     (burst)
    );

    ec_mbx_outport #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .host_take (host_rd && sel_data),
        .in_full   (ibf),
        .in_cmd    (in_cmd),
        .burst     (burst),
        .out_full  (obf),
        .out_byte  (out_byte),
        .status    (status)
    );

    // Return path mux.
    always_comb host_rdata = sel_ctrl ? status : out_byte;

endmodule

// File: rtl/ec_mailbox_chk.sv
// Property checker for the host mailbox, attached to every instance by bind.
module ec_mailbox_chk #(
    parameter int DATA_W  = 8,
    parameter int PORT_AW = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PORT_AW-1:0] host_addr,
    input logic               host_wr,
    input logic               host_rd,
    input logic               ibf,
    input logic               obf,
    input logic               in_cmd,
    input logic [DATA_W-1:0]  in_byte,
    input logic               consume,
    input logic               load,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [DATA_W-1:0]  status,
    input logic [DATA_W-1:0]  out_byte
);

    logic hit;
    always_comb hit = (host_addr == PORT_AW'(0)) || (host_addr == PORT_AW'(4));

    // R1: reset leaves status and data port empty.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && out_byte == '0));

    // R2: an accepted write fills the latch and records its port.
    a_r2_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && hit && !ibf |=> ibf && (in_cmd == $past(host_addr == PORT_AW'(4))));

    // R3: a write while full leaves the latch untouched.
    a_r3_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && ibf |=> $stable(in_byte) && $stable(in_cmd));

    // R5: a register write only follows a consumed data byte.
    a_r5_wr_source: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(consume) && !$past(in_cmd));

    // R5: read and write strobes never overlap.
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R6 and R9: output-full rises only after a sequencer load.
    a_r6_obf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf) |-> $past(load));

    // R7: a data port read with no load pending empties the port.
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_addr == PORT_AW'(0)) && !load |=> !obf);

endmodule

bind ec_mailbox ec_mailbox_chk #(.DATA_W(DATA_W), .PORT_AW(PORT_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .ibf       (ibf),
    .obf       (obf),
    .in_cmd    (in_cmd),
    .in_byte   (in_byte),
    .consume   (consume),
    .load      (load),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .status    (status),
    .out_byte  (out_byte)
);

// File: tb/ec_mailbox_tb.sv
module ec_mailbox_tb;

    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = 3'd4;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic       reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] rdq;

    always #2 clk = ~clk;

    ec_mailbox #(.DATA_W(8), .ADDR_W(8), .PORT_AW(3), .LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register space model with one-cycle read data.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
            rdq <= '0;
        end else begin
            if (reg_rd) begin rdq <= mem[reg_addr]; rd_count <= rd_count + 1; end
            if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_count <= wr_count + 1; end
        end
    end
    assign reg_rdata = rdq;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_flag(input int bitpos, input logic val);
        host_addr = 3'd4;
        for (int n = 0; n < 200; n++) begin
            #1;
            if (host_rdata[bitpos] == val) break;
            @(negedge clk);
        end
    endtask

    task automatic hwrite(input logic is_cmd, input logic [7:0] v);
        wait_flag(1, 1'b0);
        host_addr  = is_cmd ? 3'd4 : 3'd0;
        host_wdata = v;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
        host_addr  = 3'd4;
    endtask

    task automatic hread(output logic [7:0] v);
        wait_flag(0, 1'b1);
        host_addr = 3'd0;
        #1 v = host_rdata;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        host_addr = 3'd4;
    endtask

    task automatic settle();
        wait_flag(1, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        int wc;
        int rc;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
        repeat (4) @(negedge clk);
        host_addr = 3'd4; #1;
        chk("R1 status", host_rdata, 0);
        host_addr = 3'd0; #1;
        chk("R1 data", host_rdata, 0);
        host_addr = 3'd4;
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R4: measure input-full window after a command write.
        hwrite(1'b1, 8'h83);
        #1 chk("R4 cmd bit", host_rdata[3], 1);
        n = 0;
        while (host_rdata[1] && n < 100) begin n++; @(negedge clk); #1; end
        chk("R2 ibf window", n, LAT);

        // R4 / R11: stray data byte in idle.
        wc = wr_count; rc = rd_count;
        hwrite(1'b0, 8'h33);
        #1 chk("R4 data bit", host_rdata[3], 0);
        settle();
        chk("R11 stray no wr", wr_count, wc);
        chk("R11 stray no rd", rd_count, rc);

        // R8: burst flag.
        hwrite(1'b1, 8'h82); settle();
        #1 chk("R8 burst on", host_rdata[4], 1);
        hwrite(1'b1, 8'h83); settle();
        #1 chk("R8 burst off", host_rdata[4], 0);

        // R9 / R7: query reply.
        hwrite(1'b1, 8'h84);
        hread(v);
        chk("R9 query value", v, 0);
        #1 chk("R7 obf cleared", host_rdata[0], 0);

        // R5: store a computed value at every location.
        for (int a = 0; a < 256; a++) begin
            logic [7:0] val;
            val = 8'((a * 7 + 3) ^ (a >> 3));
            hwrite(1'b1, 8'h81);
            hwrite(1'b0, 8'(a));
            hwrite(1'b0, val);
            exp_mem[a] = val;
        end
        settle();
        chk("R5 write count", wr_count, 256 + wc);

        // R6 / R7: read every location back.
        for (int a = 0; a < 256; a++) begin
            hwrite(1'b1, 8'h80);
            hwrite(1'b0, 8'(a));
            hread(v);
            chk("R6 readback", v, exp_mem[a]);
        end
        #1 chk("R7 obf after sweep", host_rdata[0], 0);

        // R3: write while full is dropped.
        wait_flag(1, 1'b0);
        host_addr = 3'd4; host_wdata = 8'h81; host_wr = 1'b1;
        @(negedge clk);
        host_addr = 3'd0; host_wdata = 8'hEE;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 3'd4;
        #1 chk("R3 cmd flag kept", host_rdata[3], 1);
        hwrite(1'b0, 8'h20);
        hwrite(1'b0, 8'h5A);
        exp_mem[8'h20] = 8'h5A;
        settle();
        chk("R3 target written", mem[8'h20], 8'h5A);
        chk("R3 no stray write", mem[8'hEE], exp_mem[8'hEE]);

        // R10: command mid-sequence aborts the store.
        wc = wr_count;
        hwrite(1'b1, 8'h81);
        hwrite(1'b0, 8'h40);
        hwrite(1'b1, 8'h80);
        hwrite(1'b0, 8'h40);
        hread(v);
        chk("R10 read after abort", v, exp_mem[8'h40]);
        chk("R10 no write", wr_count, wc);

        // R11: unknown opcode followed by data bytes.
        wc = wr_count; rc = rd_count;
        hwrite(1'b1, 8'h90);
        hwrite(1'b0, 8'h01);
        hwrite(1'b0, 8'h02);
        settle();
        chk("R11 unknown no wr", wr_count, wc);
        chk("R11 unknown no rd", rd_count, rc);
        #1 chk("R11 no reply", host_rdata[0], 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule